// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two threshold values that a synchronous FIFO compares against its fill level to raise its "almost empty" and "almost full" indications. Each threshold is a 16-bit offset held as two bytes, so the block stores four bytes in total. Software or a board controller can program them in one of two ways. The first is a serial bit stream, one bit per clock edge. The second is a byte-wide parallel bus, where each write goes to the next byte in a fixed sequence. A parallel read port returns the bytes in the same sequence.

A master reset does three things. It loads the defaults for both offsets, and the level of the program pin during reset chooses which set. It latches which programming method is allowed until the next reset. It sends both byte pointers back to the first byte. When the program pin is high, the write and read enables are passed on as ordinary FIFO memory strobes. The memory array and the threshold comparators sit outside this block.

Top module: `flag_off_loader`

## Requirements
- R1: With `prog_n` low during master reset, both offsets read 0x007F after reset.
- R2: With `prog_n` high during master reset, both offsets read 0x03FF after reset.
- R3: In parallel mode, `prog_n` low with `wr_en` high stores `din[7:0]` into the byte at the write pointer. Bit 8 of `din` is ignored. The pointer then advances through byte 0 = empty low, byte 1 = empty high, byte 2 = full low, byte 3 = full high, and wraps from byte 3 to byte 0.
- R4: `prog_n` low with `rd_en` high places the byte at the read pointer on `dout[7:0]` after the next rising edge, with `dout[8]` = 0. The read pointer then advances in the same order as the write pointer and wraps in the same way. `dout` resets to 0 and holds when no read is made.
- R5: In serial mode, `prog_n` low with `ser_en` high shifts `ser_din` into a 32-bit chain on each rising edge. After 32 shifts, the first bit lands in bit 0 of the empty offset and the last bit lands in bit 15 of the full offset.
- R6: The method is latched at reset from `strap_serial` (1 = serial, 0 = parallel). A request for the other method leaves both offsets unchanged.
- R7: Parallel reads work in both serial and parallel mode.
- R8: With `prog_n` high, `wr_en` and `rd_en` drive `mem_wr` and `mem_rd`. No offset byte and no pointer changes. With `prog_n` low, `mem_wr` and `mem_rd` stay 0.
- R9: Master reset returns both the read pointer and the write pointer to byte 0.
- R10: When a parallel write and a parallel read hit the same byte in one cycle, the read returns the contents from before the write.
- R11: A change of `strap_serial` after reset does not change the latched method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| rst_n | input | 1 | Master reset, active low; asserted asynchronously, released synchronously inside the block |
| strap_serial | input | 1 | Programming method sampled during reset: 1 = serial, 0 = parallel |
| prog_n | input | 1 | Low selects offset register access; its level during reset selects the default set |
| wr_en | input | 1 | Write request, either a parallel byte write or a memory write |
| rd_en | input | 1 | Read request, either a parallel byte read or a memory read |
| ser_en | input | 1 | Serial shift request |
| ser_din | input | 1 | Serial data bit |
| din | input | 9 | Parallel write data; bits 7:0 are used |
| dout | output | 9 | Parallel read data; bit 8 is always 0 |
| mem_wr | output | 1 | FIFO memory write strobe |
| mem_rd | output | 1 | FIFO memory read strobe |
| empty_off | output | 16 | Almost-empty offset |
| full_off | output | 16 | Almost-full offset |

## Verification
A parallel byte write and a parallel byte read can be accepted in the same clock, because each has its own pointer. The bench sets the two pointers to the same byte and then raises `wr_en` and `rd_en` together. The scoreboard records the expected read value from its model before it applies the write, so `dout` must show the old byte and the following read of that byte must show the new one. A serial request and a parallel write can also arrive together. Only the request that matches the latched method may act, and the bench checks this from the offset outputs.

// File: rtl/flag_off_pkg.sv
package flag_off_pkg;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  typedef struct packed {
    logic pwr;     // parallel byte write accepted
    logic prd;     // parallel byte read accepted
    logic sshift;  // serial shift accepted
    logic mwr;     // memory write strobe
    logic mrd;     // memory read strobe
  } acc_req_t;

endpackage

// File: rtl/flag_off_rstsync.sv
module flag_off_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/flag_off_decode.sv
module flag_off_decode
  import flag_off_pkg::*;
(
  input  logic     clk,
  input  logic     core_rdy,
  input  logic     strap_serial,
  input  logic     prog_n,
  input  logic     wr_en,
  input  logic     rd_en,
  input  logic     ser_en,
  output acc_req_t req
);

  prog_mode_e mode_q;
  prog_mode_e mode_d;
  logic       mode_en;

  // method is captured continuously while reset is held, frozen afterwards
  always_comb begin
    mode_en = !core_rdy;
    mode_d  = prog_mode_e'(strap_serial);
  end

  always_ff @(posedge clk) begin
    if (mode_en) mode_q <= mode_d;
  end

  always_comb begin
    req        = '0;
    req.pwr    = core_rdy && !prog_n && wr_en  && (mode_q == PROG_PARALLEL);
    req.sshift = core_rdy && !prog_n && ser_en && (mode_q == PROG_SERIAL);
    req.prd    = core_rdy && !prog_n && rd_en;
    req.mwr    = core_rdy &&  prog_n && wr_en;
    req.mrd    = core_rdy &&  prog_n && rd_en;
  end

  // R6, R11: the latched method never moves outside reset
  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!core_rdy)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/flag_off_regs.sv
module flag_off_regs #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int OFF_W     = 16,
  parameter logic [OFF_W-1:0] DEF_LO = 16'h007F,
  parameter logic [OFF_W-1:0] DEF_HI = 16'h03FF,
  localparam int PTR_W    = $clog2(NUM_BYTES),
  localparam int TOT_W    = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              core_rdy,
  input  logic              dflt_hi,
  input  logic              pwr,
  input  logic              sshift,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ser_bit,
  output logic [TOT_W-1:0]  store_o
);

  localparam int BYTES_PER_OFF = OFF_W / BYTE_W;
  localparam int LAST_IDX      = NUM_BYTES - 1;

  logic [TOT_W-1:0] store_q, store_d, dflt_vec;
  logic             store_en;
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [OFF_W-1:0] dflt_word;

  assign dflt_word = dflt_hi ? DEF_HI : DEF_LO;

  // every offset shares the same default word, replicated per byte
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_dflt
    localparam int SUB = i % BYTES_PER_OFF;
    assign dflt_vec[i*BYTE_W +: BYTE_W] = dflt_word[SUB*BYTE_W +: BYTE_W];
  end

  always_comb begin
    store_d = store_q;
    if (sshift)   store_d = {ser_bit, store_q[TOT_W-1:1]};
    else if (pwr) store_d[int'(wptr_q)*BYTE_W +: BYTE_W] = wdata;
    if (!core_rdy) store_d = dflt_vec;
    store_en = !core_rdy || sshift || pwr;
  end

  always_ff @(posedge clk) begin
    if (store_en) store_q <= store_d;
  end

  always_comb begin
    wptr_d = wptr_q;
    if (pwr) wptr_d = (int'(wptr_q) == LAST_IDX) ? '0 : wptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge core_rdy) begin
    if (!core_rdy) wptr_q <= '0;
    else if (pwr)  wptr_q <= wptr_d;
  end

  assign store_o = store_q;

  // R3: each accepted write moves the pointer one byte, modulo the count
  assert_wr_step_R3: assert property (@(posedge clk) disable iff (!core_rdy)
    pwr |=> int'(wptr_q) == (int'($past(wptr_q)) + 1) % NUM_BYTES);

  // R8: no write, no pointer movement
  assert_wptr_hold_R8: assert property (@(posedge clk) disable iff (!core_rdy)
    !pwr |=> $stable(wptr_q));

  // R5: the shifted bit enters at the top of the chain
  assert_ser_entry_R5: assert property (@(posedge clk) disable iff (!core_rdy)
    sshift |=> store_q[TOT_W-1] == $past(ser_bit));

  // R6: no accepted programming, no offset change
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!core_rdy)
    (!pwr && !sshift) |=> $stable(store_q));

endmodule

// File: rtl/flag_off_rdport.sv
module flag_off_rdport #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  localparam int PTR_W    = $clog2(NUM_BYTES),
  localparam int TOT_W    = NUM_BYTES * BYTE_W,
  localparam int BUS_W    = BYTE_W + 1
) (
  input  logic             clk,
  input  logic             core_rdy,
  input  logic             prd,
  input  logic [TOT_W-1:0] store_i,
  output logic [BUS_W-1:0] dout
);

  localparam int LAST_IDX = NUM_BYTES - 1;

  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [BYTE_W-1:0] rd_byte;
  logic [BUS_W-1:0]  dout_q, dout_d;

  always_comb begin
    rd_byte = store_i[int'(rptr_q)*BYTE_W +: BYTE_W];
    dout_d  = {1'b0, rd_byte};
    rptr_d  = (int'(rptr_q) == LAST_IDX) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge core_rdy) begin
    if (!core_rdy) begin
      rptr_q <= '0;
      dout_q <= '0;
    end else if (prd) begin
      rptr_q <= rptr_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  // R4: each read moves the read pointer one byte, modulo the count
  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!core_rdy)
    prd |=> int'(rptr_q) == (int'($past(rptr_q)) + 1) % NUM_BYTES);

  // R4: output holds between reads
  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!core_rdy)
    !prd |=> $stable(dout_q));

endmodule

// File: rtl/flag_off_loader.sv
module flag_off_loader
  import flag_off_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [OFF_W-1:0] DEF_LO = 16'h007F,
  parameter logic [OFF_W-1:0] DEF_HI = 16'h03FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_serial,
  input  logic             prog_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic [BYTE_W:0]  din,
  output logic [BYTE_W:0]  dout,
  output logic             mem_wr,
  output logic             mem_rd,
  output logic [OFF_W-1:0] empty_off,
  output logic [OFF_W-1:0] full_off
);

  localparam int NUM_OFF   = 2;
  localparam int NUM_BYTES = NUM_OFF * (OFF_W / BYTE_W);
  localparam int TOT_W     = NUM_BYTES * BYTE_W;

  logic             core_rdy;
  acc_req_t         req;
  logic [TOT_W-1:0] store;

  flag_off_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rdy)
  );

  flag_off_decode u_dec (
    .clk          (clk),
    .core_rdy     (core_rdy),
    .strap_serial (strap_serial),
    .prog_n       (prog_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .ser_en       (ser_en),
    .req          (req)
  );

  flag_off_regs #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .OFF_W     (OFF_W),
    .DEF_LO    (DEF_LO),
    .DEF_HI    (DEF_HI)
  ) u_regs (
    .clk      (clk),
    .core_rdy (core_rdy),
    .dflt_hi  (prog_n),
    .pwr      (req.pwr),
    .sshift   (req.sshift),
    .wdata    (din[BYTE_W-1:0]),
    .ser_bit  (ser_din),
    .store_o  (store)
  );

  flag_off_rdport #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_rd (
    .clk      (clk),
    .core_rdy (core_rdy),
    .prd      (req.prd),
    .store_i  (store),
    .dout     (dout)
  );

  assign mem_wr    = req.mwr;
  assign mem_rd    = req.mrd;
  assign empty_off = store[OFF_W-1:0];
  assign full_off  = store[TOT_W-1 -: OFF_W];

  // R8: memory strobes only while the program pin is high
  assert_mem_gate_R8: assert property (@(posedge clk) disable iff (!core_rdy)
    (mem_wr || mem_rd) |-> prog_n);

endmodule

// File: tb/flag_off_loader_test.sv
module flag_off_loader_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_serial = 1'b0;
  logic       prog_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       ser_en = 1'b0;
  logic       ser_din = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       mem_wr, mem_rd;
  logic [15:0] empty_off, full_off;

  int n_cmp = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;
  logic mode_ser = 1'b0;
  logic [7:0] mb [4];
  int mw = 0;
  int mr = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  flag_off_loader uut (
    .clk(clk), .rst_n(rst_n), .strap_serial(strap_serial), .prog_n(prog_n),
    .wr_en(wr_en), .rd_en(rd_en), .ser_en(ser_en), .ser_din(ser_din),
    .din(din), .dout(dout), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .empty_off(empty_off), .full_off(full_off)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_offs(input string tag);
    chk(tag, {full_off, empty_off}, {mb[3], mb[2], mb[1], mb[0]});
  endtask

  // monitor: scoreboard pops one expected byte per accepted read
  always @(posedge clk) begin
    logic fire;
    fire = mon_on && !prog_n && rd_en;
    #2;
    if (fire) begin
      if (exp_q.size() == 0) chk("R4 unexpected read", {23'd0, dout}, 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), {23'd0, dout}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic do_reset(input logic ldv, input logic ser);
    logic [15:0] dv;
    @(negedge clk);
    mon_on = 0; rst_n = 0; prog_n = ldv; strap_serial = ser;
    wr_en = 0; rd_en = 0; ser_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    dv = ldv ? 16'h03FF : 16'h007F;
    mb[0] = dv[7:0]; mb[1] = dv[15:8]; mb[2] = dv[7:0]; mb[3] = dv[15:8];
    mw = 0; mr = 0; mode_ser = ser;
    exp_q.delete(); tag_q.delete();
    prog_n = 0;
    mon_on = 1;
  endtask

  // one access cycle with prog_n low; driver updates model and scoreboard
  task automatic cyc(input logic w, input logic [8:0] wd, input logic r,
                     input logic s, input logic sb, input string tag);
    logic [31:0] v;
    @(negedge clk);
    prog_n = 0; wr_en = w; rd_en = r; ser_en = s; ser_din = sb; din = wd;
    if (r) begin
      exp_q.push_back(mb[mr]); tag_q.push_back(tag);
      mr = (mr + 1) % 4;
    end
    if (w && !mode_ser) begin
      mb[mw] = wd[7:0];
      mw = (mw + 1) % 4;
    end
    if (s && mode_ser) begin
      v = {mb[3], mb[2], mb[1], mb[0]};
      v = {sb, v[31:1]};
      {mb[3], mb[2], mb[1], mb[0]} = v;
    end
    @(posedge clk);
    #1 wr_en = 0; rd_en = 0; ser_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    // R1, R9: low default set, pointers at byte 0
    do_reset(1'b0, 1'b0);
    chk_offs("R1 default low");
    chk("R4 dout reset", {23'd0, dout}, 32'd0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, "R9 R4 read order and wrap");

    // R3: writes with bit 8 set, wrap onto byte 0
    cyc(1, 9'h1A1, 0, 0, 0, "R3");
    cyc(1, 9'h0B2, 0, 0, 0, "R3");
    cyc(1, 9'h1C3, 0, 0, 0, "R3");
    cyc(1, 9'h0D4, 0, 0, 0, "R3");
    cyc(1, 9'h1E5, 0, 0, 0, "R3");
    @(negedge clk); chk_offs("R3 write order and wrap");

    // R6: serial requests ignored in parallel mode
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 1, "R6");
    @(negedge clk); chk_offs("R6 serial ignored in parallel mode");

    // R8: memory strobes with prog_n high, no register effect
    @(negedge clk);
    prog_n = 1; wr_en = 1; rd_en = 1; ser_en = 1; din = 9'h0FF;
    #1;
    chk("R8 mem_wr", {31'd0, mem_wr}, 32'd1);
    chk("R8 mem_rd", {31'd0, mem_rd}, 32'd1);
    @(posedge clk); #1 wr_en = 0; rd_en = 0; ser_en = 0;
    @(negedge clk); prog_n = 0; wr_en = 1; #1;
    chk("R8 mem_wr low when programming", {31'd0, mem_wr}, 32'd0);
    wr_en = 0;
    chk_offs("R8 offsets untouched");
    cyc(0, 0, 1, 0, 0, "R8 read pointer unmoved");

    // R10: align pointers, then write and read the same byte together
    cyc(1, 9'h011, 0, 0, 0, "R10");
    cyc(1, 9'h099, 1, 0, 0, "R10 same-cycle read gets old byte");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, "R10 read after write");
    @(negedge clk); chk_offs("R10 offsets");

    // R2, R9: high default set, serial mode
    do_reset(1'b1, 1'b1);
    chk_offs("R2 default high");
    cyc(0, 0, 1, 0, 0, "R9 R2 first byte after reset");

    // R6: parallel write ignored in serial mode
    cyc(1, 9'h055, 0, 0, 0, "R6");
    @(negedge clk); chk_offs("R6 parallel ignored in serial mode");

    // R5: 32-bit shift, first bit ends in empty bit 0
    pat = 32'hABCD_1234;
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 1, pat[i], "R5");
    @(negedge clk);
    chk("R5 serial load", {full_off, empty_off}, pat);
    chk_offs("R5 serial model");

    // R7: reads in serial mode
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, "R7 read in serial mode");

    // R11: strap change after reset has no effect
    strap_serial = 0;
    cyc(1, 9'h066, 0, 0, 0, "R11");
    @(negedge clk); chk_offs("R11 still serial, write ignored");
    cyc(0, 0, 0, 1, 0, "R11");
    @(negedge clk); chk_offs("R11 serial still accepted");

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule